// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core from three sources: a falling edge on an active-low external pin, a one-cycle timer overflow pulse and a one-cycle end-of-conversion pulse. Each request sets a latched flag in an 8-bit control/status register. The core reads and writes that register through a plain write-enable port. The read data is always visible.

On the rising edge of a periodic machine-phase strobe, the controller looks at the flags that are both pending and enabled. If the global enable is set and the core's call stack is not full, it picks the highest-priority source. It then raises a one-cycle acknowledge with that source's vector address. In the same step it clears the global enable and the serviced flag only. A return input that re-enables sets the global enable again; a plain return leaves it alone. A wake-up output shows whether any flag is pending, whatever the state of the global enable.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the register reads 0x00, `ackValid` is 0 and `wakeReq` is 0.
- R2: Register layout: bit0 global enable, bit1 external enable, bit2 timer enable, bit3 conversion enable, bit4 external flag, bit5 timer flag, bit6 conversion flag, all active high. Bit 7 always reads 0, and writing 1 to it changes nothing.
- R3: A high-to-low transition on `extPinN` sets bit4, seen on `regRdata` three clock edges after the input changes, because the pin passes through a two-stage synchronizer. A low-to-high transition sets nothing.
- R4: A one-cycle pulse on `tmrOvf` sets bit5, and one on `adcDone` sets bit6, at the next clock edge.
- R5: An acknowledge happens only when the global enable, the source enable and the source flag are all 1 and `stackFull` is 0. Otherwise all flags stay pending.
- R6: When several sources qualify, external wins over timer, and timer wins over conversion. The vectors are 0x04, 0x08 and 0x0C.
- R7: On an acknowledge, the global enable and the serviced flag are cleared. The other flags and all source enables keep their values.
- R8: Requests are resolved only at a rising edge of `phaseStrobe`. `ackValid` is a one-cycle pulse in the cycle after that edge. A strobe held high gives no further acknowledge.
- R9: A pulse on `retReenable` sets the global enable. A pulse on `retPlain` leaves it unchanged.
- R10: `wakeReq` is 1 exactly when any flag is set, whatever the value of the global enable.
- R11: A hardware set of a flag wins over a register write that clears it in the same cycle.
- R12: Flags stay set until they are serviced or cleared by a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extPinN | input | 1 | Asynchronous external request pin, active on falling edge |
| tmrOvf | input | 1 | Timer overflow pulse |
| adcDone | input | 1 | End-of-conversion pulse |
| phaseStrobe | input | 1 | Machine-phase strobe; its rising edge resolves requests |
| stackFull | input | 1 | Call stack full, blocks acknowledge |
| regWe | input | 1 | Register write enable |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data |
| retPlain | input | 1 | Return without re-enable |
| retReenable | input | 1 | Return with re-enable |
| ackValid | output | 1 | Acknowledge pulse to the core |
| ackVector | output | 8 | Vector address of the acknowledged source |
| wakeReq | output | 1 | Wake-up request |

## Verification
The main function is tried with every combination of the three flags, the three source enables, the global enable and the stack-full input (256 patterns). Each pattern is loaded by register write and then resolved with one strobe. This separates wrong priority, wrong vectors, a missing gate and over-clearing of flags. Directed patterns then check the synchronizer latency on both pin directions, requests held without a strobe and a strobe held high, a hardware set colliding with a software clear, and the two kinds of return.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC  = 3;
  localparam int VEC_W    = 8;
  localparam int VEC_BASE = 4;
  localparam int VEC_STEP = 4;
  localparam int REG_W    = 2 * NUM_SRC + 2;

  typedef struct packed {
    logic               take;
    logic [NUM_SRC-1:0] clrMask;
  } ctrl_strobe_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extPinN,
  input  logic               tmrOvf,
  input  logic               adcDone,
  input  logic               phaseStrobe,
  input  logic               regWe,
  input  logic [REG_W-1:0]   regWdata,
  input  logic               retPlain,
  input  logic               retReenable,
  input  ctrl_strobe_t       strb,
  output logic [REG_W-1:0]   ctrlReg,
  output logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] enables,
  output logic               masterEn,
  output logic               strobeRise,
  output logic               wakeReq
);
  logic [SYNC_STAGES:0] syncQ;
  logic                 strobeQ;
  logic                 extFall;
  logic [NUM_SRC-1:0]   hwSet;
  logic [NUM_SRC-1:0]   flagBase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '1;
      strobeQ <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-1:0], extPinN};
      strobeQ <= phaseStrobe;
    end
  end

  assign extFall    = syncQ[SYNC_STAGES] & ~syncQ[SYNC_STAGES-1];
  assign strobeRise = phaseStrobe & ~strobeQ;
  assign hwSet      = {adcDone, tmrOvf, extFall};
  assign flagBase   = regWe ? regWdata[2*NUM_SRC:NUM_SRC+1] : flags;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags    <= '0;
      enables  <= '0;
      masterEn <= 1'b0;
    end else begin
      flags <= (flagBase & ~strb.clrMask) | hwSet;
      if (regWe) enables <= regWdata[NUM_SRC:1];
      if (strb.take)        masterEn <= 1'b0;
      else if (retReenable) masterEn <= 1'b1;
      else if (regWe)       masterEn <= regWdata[0];
    end
  end

  assign ctrlReg = {1'b0, flags, enables, masterEn};
  assign wakeReq = |flags;

  p_master_clr_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> !masterEn);

  p_plain_ret_r9: assert property (@(posedge clk) disable iff (!rstN)
    (retPlain && !retReenable && !strb.take && !regWe) |=> $stable(masterEn));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hold
    p_flag_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
      (flags[i] && !regWe && !strb.clrMask[i]) |=> flags[i]);
  end
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] flags,
  input  logic [NUM_SRC-1:0] enables,
  input  logic               masterEn,
  input  logic               stackFull,
  input  logic               strobeRise,
  output ctrl_strobe_t       strb,
  output logic               ackValid,
  output logic [VEC_W-1:0]   ackVector
);
  logic [NUM_SRC-1:0] ready;
  logic [NUM_SRC-1:0] winner;
  logic [VEC_W-1:0]   winVec;
  logic               grant;

  assign ready = flags & enables;
  assign grant = strobeRise & masterEn & ~stackFull & (|ready);

  always_comb begin
    winner = '0;
    winVec = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (ready[i]) begin
        winner = '0;
        winner[i] = 1'b1;
        winVec = VEC_W'(VEC_BASE + VEC_STEP * i);
      end
    end
  end

  assign strb.take    = grant;
  assign strb.clrMask = grant ? winner : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackValid  <= 1'b0;
      ackVector <= '0;
    end else begin
      ackValid <= grant;
      if (grant) ackVector <= winVec;
    end
  end

  p_ack_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> ($past(masterEn) && !$past(stackFull)));

  p_ack_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(strobeRise));

  p_vec_prio_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackVector != VEC_W'(VEC_BASE)) |-> !($past(flags[0]) && $past(enables[0])));
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             extPinN,
  input  logic             tmrOvf,
  input  logic             adcDone,
  input  logic             phaseStrobe,
  input  logic             stackFull,
  input  logic             regWe,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  logic             retPlain,
  input  logic             retReenable,
  output logic             ackValid,
  output logic [VEC_W-1:0] ackVector,
  output logic             wakeReq
);
  ctrl_strobe_t       strb;
  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] enables;
  logic               masterEn;
  logic               strobeRise;

  irq_datapath #(.SYNC_STAGES(2)) dp_i (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .tmrOvf(tmrOvf), .adcDone(adcDone),
    .phaseStrobe(phaseStrobe), .regWe(regWe), .regWdata(regWdata),
    .retPlain(retPlain), .retReenable(retReenable), .strb(strb),
    .ctrlReg(regRdata), .flags(flags), .enables(enables), .masterEn(masterEn),
    .strobeRise(strobeRise), .wakeReq(wakeReq)
  );

  irq_control ctl_i (
    .clk(clk), .rstN(rstN), .flags(flags), .enables(enables), .masterEn(masterEn),
    .stackFull(stackFull), .strobeRise(strobeRise), .strb(strb),
    .ackValid(ackValid), .ackVector(ackVector)
  );
endmodule

// File: tb/irq_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extPinN = 1'b1, tmrOvf = 1'b0, adcDone = 1'b0, phaseStrobe = 1'b0;
  logic stackFull = 1'b0, regWe = 1'b0, retPlain = 1'b0, retReenable = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata, ackVector;
  logic ackValid, wakeReq;
  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  irq_ctrl_top dut_i (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .tmrOvf(tmrOvf), .adcDone(adcDone),
    .phaseStrobe(phaseStrobe), .stackFull(stackFull), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .retPlain(retPlain), .retReenable(retReenable),
    .ackValid(ackValid), .ackVector(ackVector), .wakeReq(wakeReq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic writeReg(logic [7:0] v);
    @(negedge clk); regWe = 1'b1; regWdata = v;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic pulseStrobe();
    @(negedge clk); phaseStrobe = 1'b1;
    @(negedge clk); phaseStrobe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reg", regRdata, 8'h00);
    check("R1 ack", {7'b0, ackValid}, 8'h00);
    check("R1 wake", {7'b0, wakeReq}, 8'h00);

    writeReg(8'hFF);
    check("R2 bit7 ignored", regRdata, 8'h7F);
    writeReg(8'hA5);
    check("R2 layout", regRdata, 8'h25);

    // exhaustive sweep: flags x enables x global enable x stack full
    for (int c = 0; c < 256; c++) begin
      logic [2:0] fl, en, rdy, win;
      logic m, full, expAck;
      logic [7:0] expVec, expReg;
      fl = c[2:0]; en = c[5:3]; m = c[6]; full = c[7];
      writeReg({1'b0, fl, en, m});
      check("R10 wake", {7'b0, wakeReq}, {7'b0, |fl});
      stackFull = full;
      pulseStrobe();
      rdy = fl & en;
      expAck = m && !full && (rdy != 0);
      win = rdy[0] ? 3'b001 : rdy[1] ? 3'b010 : rdy[2] ? 3'b100 : 3'b000;
      expVec = rdy[0] ? 8'h04 : rdy[1] ? 8'h08 : 8'h0C;
      expReg = expAck ? {1'b0, fl & ~win, en, 1'b0} : {1'b0, fl, en, m};
      check("R5 ack gate", {7'b0, ackValid}, {7'b0, expAck});
      if (expAck) check("R6 vector", ackVector, expVec);
      check("R7 reg after", regRdata, expReg);
      @(negedge clk);
      check("R8 single pulse", {7'b0, ackValid}, 8'h00);
      stackFull = 1'b0;
    end

    // R3 external falling edge through synchronizer
    writeReg(8'h00);
    extPinN = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R3 not yet", regRdata & 8'h10, 8'h00);
    @(negedge clk);
    check("R3 fall sets", regRdata & 8'h10, 8'h10);
    writeReg(8'h00);
    extPinN = 1'b1;
    repeat (5) @(negedge clk);
    check("R3 rise ignored", regRdata, 8'h00);

    // R4 timer and conversion pulses
    tmrOvf = 1'b1; @(negedge clk); tmrOvf = 1'b0;
    check("R4 timer", regRdata, 8'h20);
    adcDone = 1'b1; @(negedge clk); adcDone = 1'b0;
    check("R4 conv", regRdata, 8'h60);

    // R11 hardware set beats software clear
    @(negedge clk); regWe = 1'b1; regWdata = 8'h00; tmrOvf = 1'b1;
    @(negedge clk); regWe = 1'b0; tmrOvf = 1'b0;
    check("R11 set wins", regRdata, 8'h20);
    writeReg(8'h00);
    check("R12 sw clear", regRdata, 8'h00);

    // R8 no resolution without strobe; held strobe gives one ack
    writeReg(8'h13);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 no strobe", {7'b0, ackValid}, 8'h00);
    end
    check("R12 held", regRdata, 8'h13);
    @(negedge clk); phaseStrobe = 1'b1;
    @(negedge clk);
    check("R8 ack on edge", {7'b0, ackValid}, 8'h01);
    check("R6 ext vector", ackVector, 8'h04);
    regWe = 1'b1; regWdata = 8'h13;
    @(negedge clk); regWe = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 held strobe", {7'b0, ackValid}, 8'h00);
    end
    phaseStrobe = 1'b0;
    @(negedge clk);

    // R5 pending while stack full, then served
    stackFull = 1'b1;
    pulseStrobe();
    check("R5 full blocks", {7'b0, ackValid}, 8'h00);
    check("R5 still pending", regRdata, 8'h13);
    stackFull = 1'b0;
    pulseStrobe();
    check("R5 served", {7'b0, ackValid}, 8'h01);
    check("R7 cleared", regRdata, 8'h02);

    // R9 returns
    writeReg(8'h00);
    @(negedge clk); retReenable = 1'b1; @(negedge clk); retReenable = 1'b0;
    check("R9 reenable", regRdata, 8'h01);
    @(negedge clk); retPlain = 1'b1; @(negedge clk); retPlain = 1'b0;
    check("R9 plain keeps 1", regRdata, 8'h01);
    writeReg(8'h00);
    @(negedge clk); retPlain = 1'b1; @(negedge clk); retPlain = 1'b0;
    check("R9 plain keeps 0", regRdata, 8'h00);

    // R10 wake independent of global enable
    writeReg(8'h40);
    check("R10 wake no master", {7'b0, wakeReq}, 8'h01);
    writeReg(8'h00);
    check("R10 wake off", {7'b0, wakeReq}, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule